// File: doc/BRIEF.md
# Snoop-Aware Bus Backoff Sequencer

This block runs a processor's cache-line bus cycles: line fills and replacement write-backs of four doubleword transfers each. The core hands over one cycle at a time on a valid/ready request stream. The sequencer opens each cycle with a one-clock address strobe and steps the doubleword address on every ready response. A backoff input can cut into any cycle. The block then floats its bus outputs, keeps the number of finished transfers, and later restarts the cycle with a new strobe at the first transfer that did not finish.

External snoops are taken while the bus is idle or backed off. A small tag/state stub answers each snoop. A hit on a modified line raises a hit-modified output, and no further snoop is accepted until the matching snoop write-back is done. That write-back runs ahead of any interrupted cycle. When the snoop lands on the same line that an interrupted replacement was writing, the snoop write-back takes the place of the replacement.

Request stream rules: the core holds `req_valid_i`, `req_wb_i` and `req_line_i` steady until a clock in which `req_ready_o` is high. The request is taken at that edge. Ready drops while any cycle is running, while backoff is high, while a snoop is being looked up or presented, and while a modified hit is waiting.

Top module: `snoop_backoff_seq`

## Requirements
- R1: After reset the address strobe, cacheable indicator, hit-modified output and done pulse are low, the bus drive enable is high, and the request stream is ready.
- R2: A request is taken in a clock with valid and ready both high. In the next clock the address strobe is high for one clock, with write high for a replacement (`req_wb_i`=1) and low for a fill, and with the cacheable indicator high. Ready is low while a modified hit is pending.
- R3: A cycle on line L puts doubleword address L*16 + 4*b on `bus_addr_o`, where b is the transfer index 0..3. b advances on each clock after the strobe in which `rdy_i` is high and backoff is low.
- R4: In the clock after backoff is sampled high, `bus_oe_o` is low and the strobe, write and cacheable outputs are low. A ready response in the same clock as backoff does not count as a finished transfer.
- R5: After backoff is released and no write-back is owed, the interrupted cycle restarts in the next clock with a new strobe at address L*16 + 4*k, where k is the number of transfers finished before the interruption.
- R6: A snoop strobe is accepted while the bus is idle or backed off. If the snooped line is modified, the hit-modified output goes high two clocks after the strobe; otherwise it stays low.
- R7: Once the hit-modified output is high, further snoop strobes are ignored until the write-back for that hit completes.
- R8: A snoop write-back does not strobe while backoff is held, and it does not strobe before the second clock after hit-modified rises. On an idle, released bus it strobes in exactly that clock. It makes four writes at offsets 0, 4, 8, C with cacheable and hit-modified high throughout. Hit-modified falls in the clock after the last transfer.
- R9: When the snoop hits a line other than the interrupted one, the write-back runs first and the interrupted cycle resumes in the clock after its last transfer.
- R10: When the snoop hits the line of an interrupted replacement, the snoop write-back takes its place. The replacement is not restarted, and its done pulse comes in the clock after the write-back ends.
- R11: `done_o` pulses for exactly one clock, in the clock after the last transfer of a fill or replacement.
- R12: The tag stub resets odd lines to modified and even lines to shared. A fill leaves its line shared. A finished replacement or snoop write-back leaves the line non-modified (invalid when the snoop carried the invalidate qualifier, else shared), so a later snoop to it does not hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Core cycle request valid |
| req_ready_o | output | 1 | Sequencer can take a request |
| req_wb_i | input | 1 | 1 = replacement write-back, 0 = line fill |
| req_line_i | input | LINE_W | Line index of the request |
| done_o | output | 1 | One-clock pulse when a core cycle finishes |
| bus_ads_o | output | 1 | Address strobe |
| bus_addr_o | output | LINE_W+4 | Doubleword byte address |
| bus_wr_o | output | 1 | Write cycle |
| bus_cache_o | output | 1 | Cacheable cycle indicator |
| bus_oe_o | output | 1 | Bus outputs driven (low = floated) |
| rdy_i | input | 1 | Transfer ready response |
| backoff_i | input | 1 | Bus backoff request |
| snp_strobe_i | input | 1 | Snoop strobe |
| snp_inv_i | input | 1 | Snoop invalidate qualifier |
| snp_line_i | input | LINE_W | Snooped line index |
| hitm_o | output | 1 | Snoop hit a modified line |

## Verification
The assertions assume the environment sends snoop strobes only while the bus is idle or backed off. They also assume backoff and ready arrive only in the strobe and data phases of a running cycle, never as stray pulses on an idle bus that could be mistaken for transfers. The bench follows both rules: every snoop comes after the floated state has been seen at the ports or while the bus is idle, and ready is driven only in the data clocks the bench itself is counting. It also keeps the core from filling a modified line, so a snoop can only meet a suspended replacement on its own line.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [1:0] {KIND_FILL, KIND_RWB, KIND_SWB} kind_e;
  typedef enum logic [1:0] {LS_INV, LS_SHR, LS_MOD} lstate_e;
  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_DATA, PH_HOLD} phase_e;
endpackage

// File: rtl/sbs_tag_stub.sv
module sbs_tag_stub
  import sbs_pkg::*;
#(
  parameter int LINE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] rd_line_i,
  output lstate_e           rd_state_o,
  input  logic              wa_en_i,
  input  logic [LINE_W-1:0] wa_line_i,
  input  lstate_e           wa_state_i,
  input  logic              wb_en_i,
  input  logic [LINE_W-1:0] wb_line_i,
  input  lstate_e           wb_state_i
);
  localparam int NLINES = 1 << LINE_W;

  lstate_e st_q [NLINES];

  // Port a (cycle completion) wins over port b (snoop lookup).
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) st_q[i] <= (i % 2 == 1) ? LS_MOD : LS_SHR;
    end else begin
      if (wb_en_i) st_q[wb_line_i] <= wb_state_i;
      if (wa_en_i) st_q[wa_line_i] <= wa_state_i;
    end
  end

  assign rd_state_o = st_q[rd_line_i];

  AST_STUB_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    !(wa_en_i && wb_en_i && (wa_line_i == wb_line_i))); // R12
endmodule

// File: rtl/sbs_beat_ctr.sv
module sbs_beat_ctr #(
  parameter int BEATS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_i,
  input  logic [$clog2(BEATS)-1:0] ld_val_i,
  input  logic                     inc_i,
  output logic [$clog2(BEATS)-1:0] beat_o,
  output logic                     last_o
);
  localparam int BEAT_W = $clog2(BEATS);
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

  logic [BEAT_W-1:0] beat_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     beat_q <= '0;
    else if (ld_i)  beat_q <= ld_val_i;
    else if (inc_i) beat_q <= beat_q + 1'b1;
  end

  assign beat_o = beat_q;
  assign last_o = (beat_q == LAST);

  AST_BEAT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |-> !last_o); // R3
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !ld_i) |=> (beat_o == $past(beat_o) + 1'b1)); // R3
endmodule

// File: rtl/sbs_snoop_unit.sv
module sbs_snoop_unit
  import sbs_pkg::*;
#(
  parameter int LINE_W = 3,
  parameter int WB_GAP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic              inv_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              open_i,
  input  lstate_e           look_state_i,
  input  logic              wb_done_i,
  output logic [LINE_W-1:0] look_line_o,
  output logic              busy_o,
  output logic              hitm_o,
  output logic              wb_go_o,
  output logic [LINE_W-1:0] hit_line_o,
  output logic              hit_inv_o,
  output logic              upd_en_o,
  output logic [LINE_W-1:0] upd_line_o,
  output lstate_e           upd_state_o
);
  localparam int AGE_W = $clog2(WB_GAP + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WB_GAP - 1);

  logic              s1_v_q, s1_inv_q, hitm_q, hit_inv_q, accept;
  logic [LINE_W-1:0] s1_line_q, hit_line_q;
  logic [AGE_W-1:0]  age_q;

  assign accept = strobe_i && open_i && !s1_v_q && !hitm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v_q     <= 1'b0;
      s1_line_q  <= '0;
      s1_inv_q   <= 1'b0;
      hitm_q     <= 1'b0;
      hit_line_q <= '0;
      hit_inv_q  <= 1'b0;
      age_q      <= '0;
    end else begin
      s1_v_q <= accept;
      if (accept) begin
        s1_line_q <= line_i;
        s1_inv_q  <= inv_i;
      end
      if (s1_v_q && look_state_i == LS_MOD) begin
        hitm_q     <= 1'b1;
        hit_line_q <= s1_line_q;
        hit_inv_q  <= s1_inv_q;
        age_q      <= '0;
      end else if (wb_done_i) begin
        hitm_q <= 1'b0;
      end else if (hitm_q && age_q < AGE_MAX) begin
        age_q <= age_q + 1'b1;
      end
    end
  end

  assign look_line_o = s1_line_q;
  assign busy_o      = s1_v_q;
  assign hitm_o      = hitm_q;
  assign wb_go_o     = hitm_q && (age_q >= AGE_MAX);
  assign hit_line_o  = hit_line_q;
  assign hit_inv_o   = hit_inv_q;
  assign upd_en_o    = s1_v_q && (look_state_i != LS_MOD) && s1_inv_q;
  assign upd_line_o  = s1_line_q;
  assign upd_state_o = LS_INV;

  AST_HITM_FROM_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hitm_q) |-> $past(s1_v_q)); // R6
  AST_HITM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (hitm_q && !wb_done_i) |=> hitm_q); // R8
  AST_NO_SNOOP_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    hitm_q |=> !s1_v_q); // R7
endmodule

// File: rtl/snoop_backoff_seq.sv
module snoop_backoff_seq
  import sbs_pkg::*;
#(
  parameter int LINE_W = 3,
  parameter int BEATS  = 4,
  parameter int WB_GAP = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid_i,
  output logic                              req_ready_o,
  input  logic                              req_wb_i,
  input  logic [LINE_W-1:0]                 req_line_i,
  output logic                              done_o,
  output logic                              bus_ads_o,
  output logic [LINE_W+$clog2(BEATS)+1:0]   bus_addr_o,
  output logic                              bus_wr_o,
  output logic                              bus_cache_o,
  output logic                              bus_oe_o,
  input  logic                              rdy_i,
  input  logic                              backoff_i,
  input  logic                              snp_strobe_i,
  input  logic                              snp_inv_i,
  input  logic [LINE_W-1:0]                 snp_line_i,
  output logic                              hitm_o
);
  localparam int BEAT_W = $clog2(BEATS);

  phase_e            phase_q, phase_d;
  kind_e             kind_q, kind_d, park_kind_q, park_kind_d;
  logic [LINE_W-1:0] line_q, line_d, park_line_q, park_line_d;
  logic [BEAT_W-1:0] park_beat_q, park_beat_d, beat, ctr_val;
  logic              park_v_q, park_v_d, absorb_q, absorb_d, done_q, done_d, bof_q;
  logic              ctr_ld, ctr_inc, last, tag_wr, swb_done, active;
  lstate_e           tag_state, look_state, upd_state;
  logic              s1_busy, hitm, wb_go, hit_inv, upd_en;
  logic [LINE_W-1:0] hit_line, look_line, upd_line;

  sbs_beat_ctr #(.BEATS(BEATS)) u_beat (
    .clk(clk), .rst_n(rst_n), .ld_i(ctr_ld), .ld_val_i(ctr_val),
    .inc_i(ctr_inc), .beat_o(beat), .last_o(last)
  );

  sbs_snoop_unit #(.LINE_W(LINE_W), .WB_GAP(WB_GAP)) u_snoop (
    .clk(clk), .rst_n(rst_n), .strobe_i(snp_strobe_i), .inv_i(snp_inv_i),
    .line_i(snp_line_i), .open_i(phase_q == PH_IDLE || phase_q == PH_HOLD),
    .look_state_i(look_state), .wb_done_i(swb_done), .look_line_o(look_line),
    .busy_o(s1_busy), .hitm_o(hitm), .wb_go_o(wb_go), .hit_line_o(hit_line),
    .hit_inv_o(hit_inv), .upd_en_o(upd_en), .upd_line_o(upd_line),
    .upd_state_o(upd_state)
  );

  sbs_tag_stub #(.LINE_W(LINE_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .rd_line_i(look_line), .rd_state_o(look_state),
    .wa_en_i(tag_wr), .wa_line_i(line_q), .wa_state_i(tag_state),
    .wb_en_i(upd_en), .wb_line_i(upd_line), .wb_state_i(upd_state)
  );

  assign req_ready_o = (phase_q == PH_IDLE) && !backoff_i && !hitm && !s1_busy && !snp_strobe_i;

  always_comb begin
    phase_d     = phase_q;
    kind_d      = kind_q;
    line_d      = line_q;
    park_v_d    = park_v_q;
    park_kind_d = park_kind_q;
    park_line_d = park_line_q;
    park_beat_d = park_beat_q;
    absorb_d    = absorb_q;
    done_d      = 1'b0;
    ctr_ld      = 1'b0;
    ctr_val     = '0;
    ctr_inc     = 1'b0;
    tag_wr      = 1'b0;
    tag_state   = LS_SHR;
    swb_done    = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (!backoff_i && wb_go) begin
          kind_d  = KIND_SWB;
          line_d  = hit_line;
          ctr_ld  = 1'b1;
          phase_d = PH_ADDR;
        end else if (req_valid_i && req_ready_o) begin
          kind_d  = req_wb_i ? KIND_RWB : KIND_FILL;
          line_d  = req_line_i;
          ctr_ld  = 1'b1;
          phase_d = PH_ADDR;
        end
      end
      PH_ADDR: phase_d = backoff_i ? PH_HOLD : PH_DATA;
      PH_DATA: begin
        if (backoff_i) begin
          phase_d = PH_HOLD;
        end else if (rdy_i) begin
          if (!last) begin
            ctr_inc = 1'b1;
          end else begin
            tag_wr = 1'b1;
            unique case (kind_q)
              KIND_FILL: tag_state = LS_SHR;
              KIND_RWB:  tag_state = LS_INV;
              default:   tag_state = hit_inv ? LS_INV : LS_SHR;
            endcase
            if (kind_q == KIND_SWB) begin
              swb_done = 1'b1;
              done_d   = absorb_q;
              absorb_d = 1'b0;
              if (park_v_q) begin
                kind_d   = park_kind_q;
                line_d   = park_line_q;
                ctr_ld   = 1'b1;
                ctr_val  = park_beat_q;
                park_v_d = 1'b0;
                phase_d  = PH_ADDR;
              end else begin
                phase_d = PH_IDLE;
              end
            end else begin
              done_d  = 1'b1;
              phase_d = PH_IDLE;
            end
          end
        end
      end
      PH_HOLD: begin
        if (!backoff_i && !s1_busy) begin
          if (!hitm) begin
            phase_d = PH_ADDR;
          end else if (wb_go) begin
            phase_d = PH_ADDR;
            if (kind_q == KIND_RWB && line_q == hit_line) begin
              kind_d   = KIND_SWB;
              absorb_d = 1'b1;
              ctr_ld   = 1'b1;
            end else if (kind_q != KIND_SWB) begin
              park_v_d    = 1'b1;
              park_kind_d = kind_q;
              park_line_d = line_q;
              park_beat_d = beat;
              kind_d      = KIND_SWB;
              line_d      = hit_line;
              ctr_ld      = 1'b1;
            end
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      kind_q      <= KIND_FILL;
      line_q      <= '0;
      park_v_q    <= 1'b0;
      park_kind_q <= KIND_FILL;
      park_line_q <= '0;
      park_beat_q <= '0;
      absorb_q    <= 1'b0;
      done_q      <= 1'b0;
      bof_q       <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      kind_q      <= kind_d;
      line_q      <= line_d;
      park_v_q    <= park_v_d;
      park_kind_q <= park_kind_d;
      park_line_q <= park_line_d;
      park_beat_q <= park_beat_d;
      absorb_q    <= absorb_d;
      done_q      <= done_d;
      bof_q       <= backoff_i;
    end
  end

  assign active      = (phase_q == PH_ADDR || phase_q == PH_DATA) && !bof_q;
  assign bus_oe_o    = !bof_q;
  assign bus_ads_o   = (phase_q == PH_ADDR) && !bof_q;
  assign bus_addr_o  = active ? {line_q, beat, 2'b00} : '0;
  assign bus_wr_o    = active && (kind_q != KIND_FILL);
  assign bus_cache_o = active;
  assign hitm_o      = hitm;
  assign done_o      = done_q;

  AST_BOFF_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    backoff_i |=> !bus_oe_o); // R4
  AST_FLOAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_o |-> (!bus_ads_o && !bus_cache_o && !bus_wr_o)); // R4
  AST_NO_ADS_UNDER_BOFF: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ads_o |-> $past(!backoff_i)); // R8
  AST_WB_GAP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hitm_o) |-> !bus_ads_o); // R8
  AST_WB_GAP_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hitm_o) |=> !bus_ads_o); // R8
  AST_SWB_UNDER_HITM: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && kind_q == KIND_SWB) |-> hitm_o); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R11
  AST_HOLD_KEEPS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HOLD && backoff_i) |=> $stable(beat)); // R5
endmodule

// File: tb/test_snoop_backoff_seq.sv
`timescale 1ns/1ps
module test_snoop_backoff_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_wb = 1'b0, rdy = 1'b0, backoff = 1'b0;
  logic snp = 1'b0, snp_inv = 1'b0;
  logic [2:0] req_line = '0, snp_line = '0;
  logic req_ready, done, ads, wr, cache, oe, hitm;
  logic [6:0] addr;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  snoop_backoff_seq i_snoop_backoff_seq (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_wb_i(req_wb), .req_line_i(req_line), .done_o(done), .bus_ads_o(ads),
    .bus_addr_o(addr), .bus_wr_o(wr), .bus_cache_o(cache), .bus_oe_o(oe),
    .rdy_i(rdy), .backoff_i(backoff), .snp_strobe_i(snp), .snp_inv_i(snp_inv),
    .snp_line_i(snp_line), .hitm_o(hitm)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; rdy = 1'b0; backoff = 1'b0; snp = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
  endtask

  // Snoop a line on an idle bus; returns after the clock where hitm is defined.
  task automatic idle_snoop(int line, int exp_hit, string req);
    snp = 1'b1; snp_line = 3'(line); snp_inv = 1'b0;
    tick(); snp = 1'b0;
    tick();
    chk(req, int'(hitm), exp_hit);
  endtask

  task automatic run_case(int wb, int k, int mode);
    int l, s, x, ehit;
    l = wb ? 2 * k + 1 : 2 * k;
    s = (mode == 1) ? (wb ? (l + 1) % 8 : (l + 2) % 8) :
        (mode == 2) ? (wb ? (l + 2) % 8 : (l + 3) % 8) : l;
    x = (s + 2) % 8;
    ehit = (mode >= 2) ? 1 : 0;
    do_reset();
    chk("R1", int'(ads), 0); chk("R1", int'(hitm), 0); chk("R1", int'(oe), 1);
    chk("R1", int'(req_ready), 1); chk("R1", int'(done), 0); chk("R1", int'(cache), 0);
    req_valid = 1'b1; req_wb = wb[0]; req_line = 3'(l);
    tick(); req_valid = 1'b0;
    chk("R2", int'(ads), 1); chk("R3", int'(addr), l * 16);
    chk("R2", int'(wr), wb); chk("R2", int'(cache), 1);
    tick();
    for (int i = 0; i < k; i++) begin
      chk("R3", int'(addr), l * 16 + 4 * i); chk("R3", int'(ads), 0);
      rdy = 1'b1; tick(); rdy = 1'b0;
    end
    chk("R3", int'(addr), l * 16 + 4 * k);
    backoff = 1'b1; rdy = 1'b1;   // ready in the backoff clock must not count (R4)
    tick(); rdy = 1'b0;
    chk("R4", int'(oe), 0); chk("R4", int'(ads), 0); chk("R4", int'(cache), 0);
    if (mode != 0) begin
      snp = 1'b1; snp_line = 3'(s); snp_inv = k[0];
      tick(); snp = 1'b0;
      tick();
      chk("R6", int'(hitm), ehit);
      if (ehit == 1) begin
        snp = 1'b1; snp_line = 3'(x); snp_inv = 1'b0;   // must be ignored (R7)
        tick(); snp = 1'b0;
        tick(); tick();
        chk("R7", int'(hitm), 1); chk("R8", int'(ads), 0); chk("R4", int'(oe), 0);
      end else begin
        tick();
      end
    end
    backoff = 1'b0;
    tick();
    if (ehit == 1) begin
      chk("R8", int'(ads), 1); chk("R9", int'(addr), s * 16);
      chk("R8", int'(wr), 1); chk("R8", int'(hitm), 1); chk("R8", int'(cache), 1);
      tick();
      for (int i = 0; i < 4; i++) begin
        chk("R8", int'(addr), s * 16 + 4 * i); chk("R8", int'(hitm), 1);
        rdy = 1'b1; tick(); rdy = 1'b0;
      end
      chk("R8", int'(hitm), 0);
      if (mode == 3) begin
        chk("R10", int'(done), 1); chk("R10", int'(ads), 0);
      end else begin
        chk("R9", int'(ads), 1); chk("R9", int'(addr), l * 16 + 4 * k);
        chk("R11", int'(done), 0);
      end
    end else begin
      chk("R5", int'(ads), 1); chk("R5", int'(addr), l * 16 + 4 * k); chk("R5", int'(oe), 1);
    end
    if (mode != 3) begin
      tick();
      for (int i = k; i < 4; i++) begin
        chk("R5", int'(addr), l * 16 + 4 * i);
        rdy = 1'b1; tick(); rdy = 1'b0;
      end
      chk("R11", int'(done), 1); chk("R11", int'(ads), 0);
    end
    tick();
    chk("R11", int'(done), 0);
    if (ehit == 1) begin
      idle_snoop(s, 0, "R12");
      tick();
      idle_snoop(x, 1, "R7");
      chk("R2", int'(req_ready), 0); chk("R8", int'(ads), 0);
      tick(); chk("R8", int'(ads), 0);
      tick(); chk("R8", int'(ads), 1); chk("R8", int'(addr), x * 16);
    end else if (mode == 0 && wb == 1) begin
      idle_snoop(l, 0, "R12");
    end else if (mode == 1) begin
      idle_snoop(l ^ 1, (l ^ 1) % 2, "R12");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int wb = 0; wb < 2; wb++)
      for (int k = 0; k < 4; k++)
        for (int mode = 0; mode < 4; mode++)
          if (mode != 3 || wb == 1) run_case(wb, k, mode);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule